// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control unit of a small accumulator machine. It walks each instruction through a fetch phase, an effective-address slot and an execute phase. It owns the program counter, the memory address and data registers, the instruction register and the accumulator. It drives one single-port memory whose read data returns one cycle after the read strobe. An external combinational ALU receives an operation select and two operands. It returns a result and a condition flag that is high when the result is zero.

Instructions are 16 bits wide. Bit 15 marks an indirect reference, bits 14:12 hold the opcode and bits 11:0 hold an address. Opcode 7 is a register/I-O group. In that group, bits 11:9 select one of eight operations, and each one finishes in the effective-address slot. A single level-sensitive interrupt line is taken at instruction boundaries. It is also taken at one abort point inside memory-operand instructions, before anything commits. An aborted instruction is fetched again and runs in full after the service routine returns.

Top module: `icycle_seq`

## Requirements
- R1: When reset is released, PC holds RESET_VEC and the sequencer is in the first fetch cycle, so the first memory read (at RESET_VEC) appears in the second cycle.
- R2: Fetch takes four cycles. In cycle 1, PC is copied to the address register. In cycle 2, a read is issued at PC and PC increments. In cycle 3, read data is captured into the data register. In cycle 4, the data register moves into the instruction register and its address field into the address register.
- R3: Memory-operand opcodes are 0 AND, 1 ADD, 2 LOAD, 6 SUB and 3 STORE. AND, ADD, LOAD and SUB read the operand and write the ALU result to the accumulator. STORE writes the accumulator to memory. The ALU select encoding is 0 AND, 1 ADD, 2 pass B, 3 A minus B, 4 NOT A, 5 A shifted left by one, 6 pass A. A is the accumulator and B is the data register.
- R4: After decode, a memory reference with bit 15 set reads its pointer word in the effective-address slot and loads the address register from it, which costs one extra cycle. A direct reference makes no memory access in that slot.
- R5: Opcode 7 completes in the effective-address slot (5 cycles in total) and never enters execute. Bits 11:9 select the operation: 0 nop, 1 clear accumulator, 2 complement, 3 shift left, 4 load accumulator from io_in, 5 present accumulator on io_out with a one-cycle strobe, 6 return from interrupt, 7 enable interrupts.
- R6: Opcode 4 loads PC with the target. Opcode 5 loads PC with the target only when alu_cond is high while pass-A is selected, that is, when the accumulator is zero.
- R7: Interrupt enable is clear after reset. When irq is high with interrupts enabled at a fetch boundary, PC is saved to a return register, PC loads ISR_VEC and interrupt enable clears. A return restores PC and sets interrupt enable.
- R8: When irq is high with interrupts enabled in the first execute cycle of a memory-operand instruction, the instruction is abandoned without any read or write. The saved return address is that of the instruction itself, which then runs again in full after the return.
- R9: Read data is taken one cycle after the read strobe. Write data comes from the data register. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Write data (data register) |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd |
| alu_op | output | 3 | ALU operation select |
| alu_a | output | DATA_W | ALU operand A (accumulator) |
| alu_b | output | DATA_W | ALU operand B (data register) |
| alu_res | input | DATA_W | ALU result |
| alu_cond | input | 1 | ALU condition: result is zero |
| io_in | input | DATA_W | Input port sampled by group op 4 |
| io_out | output | DATA_W | Output port written by group op 5 |
| io_out_stb | output | 1 | One-cycle strobe when io_out is written |
| irq | input | 1 | Interrupt request, level sensitive |

## Verification
The hardest case to reach from the ports is an interrupt that lands in the first execute cycle of a memory-operand instruction. That is the only abort point, and it lasts a single cycle. The bench runs one fixed program of load, add, store, indirect load and store. It sweeps the cycle at which irq rises across every position in that program, so each boundary and each abort point is hit in turn. For every position it checks that each store reached memory exactly once with the right value and that the service routine ran once.

// File: rtl/icseq_pkg.sv
package icseq_pkg;

   localparam int IW = 16;

   typedef enum logic [2:0] {
      OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
      OP_JMP = 3'd4, OP_BZ  = 3'd5, OP_SUB = 3'd6, OP_GRP = 3'd7
   } opc_e;

   typedef enum logic [2:0] {
      G_NOP = 3'd0, G_CLA = 3'd1, G_CMA = 3'd2, G_SHL = 3'd3,
      G_INP = 3'd4, G_OUT = 3'd5, G_RTI = 3'd6, G_ION = 3'd7
   } grp_e;

   typedef enum logic [2:0] {
      ALU_AND = 3'd0, ALU_ADD = 3'd1, ALU_PASSB = 3'd2, ALU_SUB = 3'd3,
      ALU_NOT = 3'd4, ALU_SHL = 3'd5, ALU_PASSA = 3'd6
   } alu_e;

   typedef enum logic [3:0] {
      ST_F1, ST_F2, ST_F3, ST_F4, ST_EA, ST_EAW, ST_X1, ST_X2, ST_X3
   } st_e;

   typedef struct packed {
      logic        ind;
      opc_e        op;
      grp_e        grp;
      logic [11:0] addr;
      logic        is_grp;
   } dec_t;

endpackage

// File: rtl/icseq_decode.sv
module icseq_decode
   import icseq_pkg::*;
(
   input  logic [IW-1:0] word,
   output dec_t          dec
);

   always_comb begin
      dec.ind    = word[15];
      dec.op     = opc_e'(word[14:12]);
      dec.grp    = grp_e'(word[11:9]);
      dec.addr   = word[11:0];
      dec.is_grp = (word[14:12] == 3'd7);
   end

endmodule

// File: rtl/icseq_pc.sv
module icseq_pc #(
   parameter int          AW  = 8,
   parameter int unsigned RST = 0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   output logic [AW-1:0] pc
);

   localparam logic [AW-1:0] RST_A = AW'(RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc <= RST_A;
      else if (ld)  pc <= ld_val;
      else if (inc) pc <= pc + 1'b1;
   end

endmodule

// File: rtl/icseq_irq.sv
module icseq_irq #(
   parameter int AW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enter,
   input  logic          rti,
   input  logic          ion,
   input  logic [AW-1:0] save_pc,
   output logic          ie,
   output logic [AW-1:0] ret_pc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie     <= 1'b0;
         ret_pc <= '0;
      end else if (enter) begin
         ie     <= 1'b0;
         ret_pc <= save_pc;
      end else if (rti || ion) begin
         ie     <= 1'b1;
      end
   end

endmodule

// File: rtl/icycle_seq.sv
module icycle_seq
   import icseq_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 16,
   parameter int unsigned RESET_VEC = 32'h10,
   parameter int unsigned ISR_VEC   = 32'h80,
   parameter bit          IRQ_EN    = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [2:0]        alu_op,
   output logic [DATA_W-1:0] alu_a,
   output logic [DATA_W-1:0] alu_b,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_cond,
   input  logic [DATA_W-1:0] io_in,
   output logic [DATA_W-1:0] io_out,
   output logic              io_out_stb,
   input  logic              irq
);

   localparam int                AFW   = 12;
   localparam logic [ADDR_W-1:0] ISR_A = ADDR_W'(ISR_VEC);

   if (ADDR_W < 2 || ADDR_W > AFW) begin : g_bad_aw
      $error("ADDR_W must lie in 2..12");
   end
   if (DATA_W < IW) begin : g_bad_dw
      $error("DATA_W must be at least 16");
   end

   st_e               state;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mdr;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] out_q;
   logic              out_stb_q;
   logic [IW-1:0]     ir;
   dec_t              dec;

   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] pc_nxt;
   logic [ADDR_W-1:0] save_pc;
   logic [ADDR_W-1:0] ret_pc;
   logic              pc_ld;
   logic              pc_inc;
   logic              ie;
   logic              mem_op_w;
   logic              load_op;
   logic              take_brk;
   logic              take_abt;
   logic              enter;
   logic              rti_w;
   logic              ion_w;
   alu_e              alu_sel;

   icseq_decode u_dec (
      .word (ir),
      .dec  (dec)
   );

   icseq_pc #(.AW(ADDR_W), .RST(RESET_VEC)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (pc_inc),
      .ld     (pc_ld),
      .ld_val (pc_nxt),
      .pc     (pc)
   );

   if (IRQ_EN) begin : g_irq
      icseq_irq #(.AW(ADDR_W)) u_irq (
         .clk     (clk),
         .rst_n   (rst_n),
         .enter   (enter),
         .rti     (rti_w),
         .ion     (ion_w),
         .save_pc (save_pc),
         .ie      (ie),
         .ret_pc  (ret_pc)
      );
   end else begin : g_no_irq
      assign ie     = 1'b0;
      assign ret_pc = '0;
   end

   // instruction class and interrupt sampling points
   always_comb begin
      mem_op_w = !dec.is_grp && (dec.op != OP_JMP) && (dec.op != OP_BZ);
      load_op  = mem_op_w && (dec.op != OP_STA);
      take_brk = (state == ST_F1) && irq && ie;
      take_abt = (state == ST_X1) && mem_op_w && irq && ie;
      enter    = take_brk || take_abt;
      save_pc  = take_abt ? pc - 1'b1 : pc;
      rti_w    = (state == ST_EA) && dec.is_grp && (dec.grp == G_RTI);
      ion_w    = (state == ST_EA) && dec.is_grp && (dec.grp == G_ION);
   end

   // program counter control
   always_comb begin
      pc_inc = (state == ST_F2);
      pc_ld  = 1'b0;
      pc_nxt = ISR_A;
      if (enter) begin
         pc_ld  = 1'b1;
      end else if (state == ST_X1 && dec.op == OP_JMP) begin
         pc_ld  = 1'b1;
         pc_nxt = mar;
      end else if (state == ST_X1 && dec.op == OP_BZ && alu_cond) begin
         pc_ld  = 1'b1;
         pc_nxt = mar;
      end else if (rti_w) begin
         pc_ld  = 1'b1;
         pc_nxt = ret_pc;
      end
   end

   // ALU select
   always_comb begin
      alu_sel = ALU_PASSA;
      if (state == ST_X3) begin
         case (dec.op)
            OP_AND:  alu_sel = ALU_AND;
            OP_ADD:  alu_sel = ALU_ADD;
            OP_SUB:  alu_sel = ALU_SUB;
            default: alu_sel = ALU_PASSB;
         endcase
      end else if (state == ST_EA && dec.is_grp) begin
         if (dec.grp == G_CMA)      alu_sel = ALU_NOT;
         else if (dec.grp == G_SHL) alu_sel = ALU_SHL;
      end
   end

   // memory strobes
   always_comb begin
      mem_rd = (state == ST_F2)
            || (state == ST_EA && !dec.is_grp && dec.ind)
            || (state == ST_X1 && load_op && !take_abt);
      mem_wr = (state == ST_X2) && (dec.op == OP_STA);
   end

   assign mem_addr   = mar;
   assign mem_wdata  = mdr;
   assign alu_op     = alu_sel;
   assign alu_a      = acc;
   assign alu_b      = mdr;
   assign io_out     = out_q;
   assign io_out_stb = out_stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_F1;
         mar       <= '0;
         mdr       <= '0;
         ir        <= '0;
         acc       <= '0;
         out_q     <= '0;
         out_stb_q <= 1'b0;
      end else begin
         out_stb_q <= 1'b0;
         unique case (state)
            ST_F1: begin
               if (!take_brk) begin
                  mar   <= pc;
                  state <= ST_F2;
               end
            end
            ST_F2: state <= ST_F3;
            ST_F3: begin
               mdr   <= mem_rdata;
               state <= ST_F4;
            end
            ST_F4: begin
               ir    <= mdr[IW-1:0];
               mar   <= mdr[ADDR_W-1:0];
               state <= ST_EA;
            end
            ST_EA: begin
               if (dec.is_grp) begin
                  case (dec.grp)
                     G_CLA:        acc <= '0;
                     G_CMA, G_SHL: acc <= alu_res;
                     G_INP:        acc <= io_in;
                     G_OUT: begin
                        out_q     <= acc;
                        out_stb_q <= 1'b1;
                     end
                     default: ;
                  endcase
                  state <= ST_F1;
               end else if (dec.ind) begin
                  state <= ST_EAW;
               end else begin
                  state <= ST_X1;
               end
            end
            ST_EAW: begin
               mar   <= mem_rdata[ADDR_W-1:0];
               state <= ST_X1;
            end
            ST_X1: begin
               if (take_abt || !mem_op_w) begin
                  state <= ST_F1;
               end else begin
                  if (dec.op == OP_STA) mdr <= acc;
                  state <= ST_X2;
               end
            end
            ST_X2: begin
               if (dec.op == OP_STA) begin
                  state <= ST_F1;
               end else begin
                  mdr   <= mem_rdata;
                  state <= ST_X3;
               end
            end
            ST_X3: begin
               acc   <= alu_res;
               state <= ST_F1;
            end
            default: state <= ST_F1;
         endcase
      end
   end

endmodule

// File: rtl/icseq_chk.sv
module icseq_chk
   import icseq_pkg::*;
#(
   parameter int          AW  = 8,
   parameter int unsigned RST = 0,
   parameter int unsigned ISR = 0
)(
   input logic          clk,
   input logic          rst_n,
   input st_e           state,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] mem_addr,
   input logic          ie,
   input logic          irq,
   input logic          mem_rd,
   input logic          mem_wr,
   input dec_t          dec
);

   // R1
   rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc == AW'(RST)) && (state == ST_F1));

   // R2
   fetch_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_F2) |-> mem_rd && !mem_wr && (mem_addr == pc));

   // R2
   pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_F2) |=> (pc == AW'($past(pc) + 1'b1)));

   // R4
   direct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EA && !dec.is_grp && !dec.ind) |-> !mem_rd && !mem_wr);

   // R4
   ind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EA && !dec.is_grp && dec.ind) |-> mem_rd && (mem_addr == dec.addr[AW-1:0]));

   // R5
   grp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EA && dec.is_grp) |=> (state == ST_F1));

   // R7
   irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_F1 && irq && ie) |=> (pc == AW'(ISR)) && !ie && (state == ST_F1));

   // R8
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_X1 && irq && ie && !dec.is_grp && dec.op != OP_JMP && dec.op != OP_BZ)
      |-> !mem_rd && !mem_wr);

   // R8
   abort_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_X1 && irq && ie && !dec.is_grp && dec.op != OP_JMP && dec.op != OP_BZ)
      |=> (pc == AW'(ISR)) && !ie);

   // R9
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

endmodule

bind icycle_seq icseq_chk #(.AW(ADDR_W), .RST(RESET_VEC), .ISR(ISR_VEC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .pc       (pc),
   .mem_addr (mem_addr),
   .ie       (ie),
   .irq      (irq),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .dec      (dec)
);

// File: tb/icycle_seq_test.sv
module icycle_seq_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = 8;
   localparam int DW = 16;
   localparam int RV = 'h10;
   localparam int IV = 'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [2:0]    alu_op;
   logic [DW-1:0] alu_a, alu_b, alu_res;
   logic          alu_cond;
   logic [DW-1:0] io_in, io_out;
   logic          io_out_stb;
   logic          irq;

   logic [DW-1:0] mem [256];
   int            total = 0;
   int            bad = 0;
   int            nrd, nout;
   int            rd_cyc [16];
   int            rd_adr [16];
   logic [DW-1:0] outv [8];
   int            wcnt [256];
   logic [DW-1:0] vals [6] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};

   always #2.5 clk = ~clk;

   icycle_seq #(.ADDR_W(AW), .DATA_W(DW), .RESET_VEC(RV), .ISR_VEC(IV)) uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .alu_op(alu_op), .alu_a(alu_a),
      .alu_b(alu_b), .alu_res(alu_res), .alu_cond(alu_cond), .io_in(io_in),
      .io_out(io_out), .io_out_stb(io_out_stb), .irq(irq)
   );

   // ALU model from the R3 encoding; condition = zero result
   always_comb begin
      case (alu_op)
         3'd0:    alu_res = alu_a & alu_b;
         3'd1:    alu_res = alu_a + alu_b;
         3'd2:    alu_res = alu_b;
         3'd3:    alu_res = alu_a - alu_b;
         3'd4:    alu_res = ~alu_a;
         3'd5:    alu_res = alu_a << 1;
         default: alu_res = alu_a;
      endcase
      alu_cond = (alu_res == '0);
   end

   // memory with one-cycle read latency
   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   function automatic logic [15:0] mi(input bit ind, input int op, input int adr);
      return {ind, 3'(op), 12'(adr)};
   endfunction

   function automatic logic [15:0] gi(input int sub);
      return {1'b0, 3'd7, 3'(sub), 9'd0};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr_mem();
      for (int i = 0; i < 256; i++) mem[i] = '0;
   endtask

   task automatic run(input int ncyc, input int irq_at);
      nrd = 0;
      nout = 0;
      for (int i = 0; i < 16; i++) begin rd_cyc[i] = -1; rd_adr[i] = -1; end
      for (int i = 0; i < 8; i++) outv[i] = '0;
      for (int i = 0; i < 256; i++) wcnt[i] = 0;
      irq = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b1;
      for (int c = 1; c <= ncyc; c++) begin
         @(negedge clk);
         if (c == irq_at) irq = 1'b1;
         if (mem_rd && nrd < 16) begin
            rd_cyc[nrd] = c;
            rd_adr[nrd] = int'(mem_addr);
            nrd++;
         end
         if (mem_wr) wcnt[mem_addr]++;
         if (io_out_stb) begin
            if (nout < 8) outv[nout] = io_out;
            nout++;
            irq = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      io_in = '0;
      irq = 1'b0;

      // reset state
      rst_n = 1'b0;
      #12;
      chk("R1 strobes idle in reset", int'({mem_rd, mem_wr}), 0);
      chk("R5 strobe idle in reset", int'(io_out_stb), 0);

      // fetch order and cycle timing
      clr_mem();
      mem['h10] = mi(0, 2, 'h40);
      mem['h11] = mi(1, 2, 'h41);
      mem['h12] = gi(1);
      mem['h13] = mi(0, 4, 'h13);
      mem['h40] = 16'h1111;
      mem['h41] = 16'h0044;
      mem['h44] = 16'h2222;
      run(30, -1);
      chk("R1 first fetch cycle", rd_cyc[0], 2);
      chk("R1 first fetch addr", rd_adr[0], RV);
      chk("R3 operand addr", rd_adr[1], 'h40);
      chk("R9 operand cycle", rd_cyc[1], 6);
      chk("R2 next fetch addr", rd_adr[2], 'h11);
      chk("R2 next fetch cycle", rd_cyc[2], 10);
      chk("R4 pointer addr", rd_adr[3], 'h41);
      chk("R4 pointer cycle", rd_cyc[3], 13);
      chk("R4 target addr", rd_adr[4], 'h44);
      chk("R4 target cycle", rd_cyc[4], 15);
      chk("R4 fetch after indirect", rd_adr[5], 'h12);
      chk("R4 fetch after indirect cycle", rd_cyc[5], 19);
      chk("R5 group length addr", rd_adr[6], 'h13);
      chk("R5 group length cycle", rd_cyc[6], 24);
      chk("R5 clear accumulator", int'(alu_a), 0);

      // arithmetic sweep
      for (int o = 0; o < 3; o++) begin
         for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
               int opc;
               logic [15:0] e;
               opc = (o == 0) ? 0 : (o == 1) ? 1 : 6;
               clr_mem();
               mem['h10] = mi(0, 2, 'h40);
               mem['h11] = mi(0, opc, 'h41);
               mem['h12] = mi(0, 3, 'h42);
               mem['h13] = mi(0, 4, 'h13);
               mem['h40] = vals[i];
               mem['h41] = vals[j];
               run(50, -1);
               if (o == 0)      e = vals[i] & vals[j];
               else if (o == 1) e = vals[i] + vals[j];
               else             e = vals[i] - vals[j];
               chk("R3 alu result stored", int'(mem['h42]), int'(e));
               chk("R9 single write", wcnt['h42], 1);
            end
         end
      end

      // register / io group sweep
      for (int i = 0; i < 6; i++) begin
         logic [15:0] e;
         clr_mem();
         mem['h10] = gi(4);
         mem['h11] = gi(2);
         mem['h12] = gi(3);
         mem['h13] = gi(5);
         mem['h14] = gi(1);
         mem['h15] = gi(5);
         mem['h16] = mi(0, 4, 'h16);
         io_in = vals[i];
         e = (~vals[i]) << 1;
         run(50, -1);
         chk("R5 output count", nout, 2);
         chk("R5 inp cma shl out", int'(outv[0]), int'(e));
         chk("R5 cla out", int'(outv[1]), 0);
      end

      // branch sweep
      for (int i = 0; i < 6; i++) begin
         clr_mem();
         mem['h10] = mi(0, 2, 'h40);
         mem['h11] = mi(0, 5, 'h20);
         mem['h12] = gi(5);
         mem['h13] = mi(0, 4, 'h13);
         mem['h20] = gi(4);
         mem['h21] = gi(5);
         mem['h22] = mi(0, 4, 'h22);
         mem['h40] = vals[i];
         io_in = 16'h5a5a;
         run(60, -1);
         chk("R6 branch output count", nout, 1);
         chk("R6 branch path", int'(outv[0]), (vals[i] == 0) ? 'h5a5a : int'(vals[i]));
      end

      // interrupt arrival sweep over boundaries and abort points
      for (int t = 1; t <= 64; t++) begin
         clr_mem();
         mem['h10] = gi(7);
         mem['h11] = mi(0, 2, 'h40);
         mem['h12] = mi(0, 1, 'h41);
         mem['h13] = mi(0, 3, 'h42);
         mem['h14] = mi(1, 2, 'h43);
         mem['h15] = mi(0, 3, 'h45);
         mem['h16] = mi(0, 4, 'h16);
         mem['h80] = gi(5);
         mem['h81] = gi(6);
         mem['h40] = 16'h1234;
         mem['h41] = 16'h0f0f;
         mem['h43] = 16'h0044;
         mem['h44] = 16'hbeef;
         run(150, t);
         chk("R8 sum after restart", int'(mem['h42]), 'h2143);
         chk("R8 indirect after restart", int'(mem['h45]), 'hbeef);
         chk("R8 sum written once", wcnt['h42], 1);
         chk("R8 copy written once", wcnt['h45], 1);
         chk("R7 service routine ran once", nout, 1);
      end

      // interrupts stay off without an enable
      clr_mem();
      mem['h10] = gi(0);
      mem['h11] = mi(0, 2, 'h40);
      mem['h12] = mi(0, 3, 'h42);
      mem['h13] = mi(0, 4, 'h13);
      mem['h40] = 16'h00a5;
      mem['h80] = gi(5);
      run(80, 1);
      chk("R7 ignored while disabled", nout, 0);
      chk("R7 program unaffected", int'(mem['h42]), 'h00a5);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule